// File: doc/BRIEF.md
# Table-Programmed Serial Flash Sequencer

This block drives a serial NOR flash over a clock pin, an active-low select and four bidirectional data lines. The bus transaction is not fixed in hardware. Software first loads a small instruction table through a write port. It then starts a transaction by giving a sequence number, a flash address and a data byte count. The engine steps through up to eight 16-bit instructions that belong to that sequence. Each instruction is one of the following: send an opcode byte, send address bits, idle for some clocks, write data, read data, or end. Each instruction also picks one data line or four data lines for itself.

Outgoing data comes from a small transmit FIFO and incoming data goes to a small receive FIFO. The engine does not underrun or overrun these FIFOs. It holds the serial clock low at a byte boundary until the FIFO can take part again. A typical page write uses three separate sequences: write-enable, program and status poll. Each one is started on its own trigger.

Top module: `flash_seq_engine`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, busy and done are 0, io_oe is 0, rx_empty is 1 and tx_full is 0. The table resets to all-zero words.
- R2: A start while idle with index i runs the instructions held in table words 4i to 4i+3. Bits [15:0] of a word run before bits [31:16]. An instruction has opcode bits [15:10] (0 end, 1 command, 2 address, 3 dummy, 4 write, 5 read), pad bits [9:8] (2 selects four lines, any other value one line) and operand bits [7:0].
- R3: sck idles low and each sck period is two clk cycles, with sck high in the second one. Data is sent MSB first and changes only while sck is low. One-line mode drives io_out[0] with io_oe=0001. Four-line mode drives io_out[3:0] with io_oe=1111, high nibble first. cs_n is low whenever sck is high or io_oe is nonzero.
- R4: A command instruction sends its operand byte. This takes 8 sck periods on one line or 2 on four lines.
- R5: An address instruction sends the low N bits of the trigger address, where N is the operand (at most 32, a multiple of 4 on four lines). This takes N periods on one line or N/4 on four lines. N=0 sends nothing.
- R6: A dummy instruction gives as many sck periods as its operand, with io_oe=0.
- R7: A write instruction sends xfer_len bytes popped in order from the transmit FIFO. If that FIFO is empty at a byte boundary, sck stays low and cs_n stays low until a byte arrives.
- R8: A read instruction collects xfer_len bytes into the receive FIFO. On each rising sck it samples io_in[1] (one line) or io_in[3:0] (four lines), MSB first. If the FIFO is full at a byte boundary, sck stays low until a byte is popped.
- R9: Opcode 0, or any opcode above 5, ends the sequence. In that cycle done is 1 for exactly one cycle and cs_n is already 1. busy is 0 in the next cycle.
- R10: A sequence with no end instruction finishes in the same way once its eighth instruction has completed.
- R11: A start pulse while busy has no effect on the running transaction and starts no later one.
- R12: A push into a full transmit FIFO is dropped. A pop from an empty receive FIFO changes nothing. tx_full is 1 while the transmit FIFO holds 4 bytes.
- R13: A write or read instruction with xfer_len 0 produces no sck period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbl_we | input | 1 | Table word write strobe |
| tbl_addr | input | 4 | Table word index |
| tbl_wdata | input | 32 | Table word, two instructions |
| start | input | 1 | Transaction trigger, honoured only while idle |
| seq_idx | input | 2 | Sequence number to run |
| xfer_addr | input | 32 | Flash address used by address instructions |
| xfer_len | input | 8 | Byte count for write and read instructions |
| busy | output | 1 | High from trigger until the cycle after done |
| done | output | 1 | One-cycle end-of-sequence pulse |
| tx_push | input | 1 | Transmit FIFO push |
| tx_data | input | 8 | Transmit byte |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Receive FIFO pop |
| rx_data | output | 8 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
The assertions take four things for granted. The instruction table is not rewritten while a sequence is running. Address operands are at most 32 bits and are a multiple of 4 in four-line mode. The flash side changes io_in only while sck is low. Triggers do nothing until the internal reset has been released. The bench writes the table only while the engine is idle and uses only legal address operands. It waits several cycles after reset before the first trigger. Its flash model updates io_in only after a falling sck edge, using a known function of how many falling edges have occurred.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int ADDR_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int SLOTS   = 8;
  localparam int SLOT_W  = $clog2(SLOTS);

  localparam logic [5:0] OPC_END   = 6'd0;
  localparam logic [5:0] OPC_CMD   = 6'd1;
  localparam logic [5:0] OPC_ADDR  = 6'd2;
  localparam logic [5:0] OPC_DUMMY = 6'd3;
  localparam logic [5:0] OPC_WRITE = 6'd4;
  localparam logic [5:0] OPC_READ  = 6'd5;

  localparam logic [1:0] PAD_QUAD  = 2'd2;

  typedef struct packed {
    logic [5:0] opc;
    logic [1:0] pad;
    logic [7:0] opnd;
  } instr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_LOW,
    ST_HIGH,
    ST_END
  } seq_state_e;

endpackage

// File: rtl/flash_seq_table.sv
module flash_seq_table #(
  parameter int WORDS = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] words_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) words_q[i] <= '0;
    end else if (wr_en) begin
      words_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = words_q[rd_addr];

endmodule

// File: rtl/flash_seq_fifo.sv
module flash_seq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wp_q, wp_d, rp_q, rp_d;
  logic         push_ok, pop_ok;

  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign empty   = (wp_q == rp_q);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem_q[rp_q[AW-1:0]];

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (push_ok) wp_d = wp_q + 1'b1;
    if (pop_ok)  rp_d = rp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wp_q[AW-1:0]] <= din;
  end

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int SEQ_W = 2,
  parameter int LEN_W = 8,
  localparam int TBL_AW = SEQ_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEQ_W-1:0]  seq_idx,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic [TBL_AW-1:0] tbl_raddr,
  input  logic [WORD_W-1:0] tbl_word,
  input  logic              tx_empty,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);

  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [SEQ_W-1:0]  seq_q, seq_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [5:0]        opc_q, opc_d;
  logic              quad_q, quad_d;
  logic [ADDR_W-1:0] sh_q, sh_d;
  logic [7:0]        units_q, units_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [7:0]        rsh_q, rsh_d;

  instr_t     cur;
  logic       cur_quad;
  logic [5:0] nbits;
  logic [7:0] addr_units;
  logic       last_slot;
  logic       drives;
  logic       shifting;

  assign tbl_raddr  = {seq_q, slot_q[SLOT_W-1:1]};
  assign cur        = slot_q[0] ? instr_t'(tbl_word[31:16]) : instr_t'(tbl_word[15:0]);
  assign cur_quad   = (cur.pad == PAD_QUAD);
  assign nbits      = (cur.opnd > 8'd32) ? 6'd32 : cur.opnd[5:0];
  assign addr_units = cur_quad ? {4'd0, nbits[5:2]} : {2'd0, nbits};
  assign last_slot  = (slot_q == SLOT_W'(SLOTS - 1));

  // next-state process
  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    seq_d   = seq_q;
    addr_d  = addr_q;
    len_d   = len_q;
    opc_d   = opc_q;
    quad_d  = quad_q;
    sh_d    = sh_q;
    units_d = units_q;
    left_d  = left_q;
    rsh_d   = rsh_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          seq_d   = seq_idx;
          addr_d  = xfer_addr;
          len_d   = xfer_len;
          slot_d  = '0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        opc_d  = cur.opc;
        quad_d = cur_quad;
        unique case (cur.opc)
          OPC_CMD: begin
            sh_d    = {cur.opnd, {(ADDR_W-8){1'b0}}};
            units_d = cur_quad ? 8'd2 : 8'd8;
            state_d = ST_LOW;
          end
          OPC_ADDR: begin
            sh_d    = addr_q << (6'd32 - nbits);
            units_d = addr_units;
            if (addr_units == 8'd0) begin
              state_d = last_slot ? ST_END : ST_FETCH;
              slot_d  = slot_q + 1'b1;
            end else begin
              state_d = ST_LOW;
            end
          end
          OPC_DUMMY: begin
            units_d = cur.opnd;
            if (cur.opnd == 8'd0) begin
              state_d = last_slot ? ST_END : ST_FETCH;
              slot_d  = slot_q + 1'b1;
            end else begin
              state_d = ST_LOW;
            end
          end
          OPC_WRITE, OPC_READ: begin
            left_d  = len_q;
            state_d = ST_LOAD;
          end
          default: state_d = ST_END;
        endcase
      end
      ST_LOAD: begin
        if (left_q == '0) begin
          state_d = last_slot ? ST_END : ST_FETCH;
          slot_d  = slot_q + 1'b1;
        end else if (opc_q == OPC_WRITE) begin
          if (!tx_empty) begin
            tx_pop  = 1'b1;
            sh_d    = {tx_byte, {(ADDR_W-8){1'b0}}};
            units_d = quad_q ? 8'd2 : 8'd8;
            left_d  = left_q - LEN_W'(1);
            state_d = ST_LOW;
          end
        end else begin
          if (!rx_full) begin
            units_d = quad_q ? 8'd2 : 8'd8;
            left_d  = left_q - LEN_W'(1);
            state_d = ST_LOW;
          end
        end
      end
      ST_LOW: begin
        state_d = ST_HIGH;
        if (opc_q == OPC_READ) begin
          rsh_d = quad_q ? {rsh_q[3:0], io_in} : {rsh_q[6:0], io_in[1]};
        end
      end
      ST_HIGH: begin
        sh_d    = quad_q ? (sh_q << 4) : (sh_q << 1);
        units_d = units_q - 8'd1;
        if (units_q == 8'd1) begin
          if (opc_q == OPC_READ) rx_push = 1'b1;
          if ((opc_q == OPC_READ) || (opc_q == OPC_WRITE)) begin
            state_d = ST_LOAD;
          end else begin
            state_d = last_slot ? ST_END : ST_FETCH;
            slot_d  = slot_q + 1'b1;
          end
        end else begin
          state_d = ST_LOW;
        end
      end
      ST_END:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      seq_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      opc_q   <= OPC_END;
      quad_q  <= 1'b0;
      sh_q    <= '0;
      units_q <= '0;
      left_q  <= '0;
      rsh_q   <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      seq_q   <= seq_d;
      addr_q  <= addr_d;
      len_q   <= len_d;
      opc_q   <= opc_d;
      quad_q  <= quad_d;
      sh_q    <= sh_d;
      units_q <= units_d;
      left_q  <= left_d;
      rsh_q   <= rsh_d;
    end
  end

  assign shifting = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign drives   = (opc_q == OPC_CMD) || (opc_q == OPC_ADDR) || (opc_q == OPC_WRITE);

  assign rx_byte = rsh_q;
  assign sck     = (state_q == ST_HIGH);
  assign cs_n    = (state_q == ST_IDLE) || (state_q == ST_END);
  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_END);
  assign io_out  = quad_q ? sh_q[ADDR_W-1 -: 4] : {3'b000, sh_q[ADDR_W-1]};
  assign io_oe   = (shifting && drives) ? (quad_q ? 4'b1111 : 4'b0001) : 4'b0000;

endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
  import flash_seq_pkg::*;
#(
  parameter int LUT_SEQS   = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int LEN_W      = 8,
  localparam int SEQ_W     = $clog2(LUT_SEQS),
  localparam int LUT_WORDS = LUT_SEQS * (SLOTS / 2),
  localparam int LUT_AW    = $clog2(LUT_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [LUT_AW-1:0] tbl_addr,
  input  logic [WORD_W-1:0] tbl_wdata,
  input  logic              start,
  input  logic [SEQ_W-1:0]  seq_idx,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              busy,
  output logic              done,
  input  logic              tx_push,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              rx_pop,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_empty,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [LUT_AW-1:0] tbl_raddr;
  logic [WORD_W-1:0] tbl_word;
  logic              tx_empty, tx_pop;
  logic [BYTE_W-1:0] tx_byte;
  logic              rx_full, rx_push;
  logic [BYTE_W-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  flash_seq_table #(.WORDS(LUT_WORDS), .DW(WORD_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_wdata),
    .rd_addr (tbl_raddr),
    .rd_data (tbl_word)
  );

  flash_seq_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (tx_push),
    .din   (tx_data),
    .pop   (tx_pop),
    .dout  (tx_byte),
    .full  (tx_full),
    .empty (tx_empty)
  );

  flash_seq_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (rx_push),
    .din   (rx_byte),
    .pop   (rx_pop),
    .dout  (rx_data),
    .full  (rx_full),
    .empty (rx_empty)
  );

  flash_seq_ctrl #(.SEQ_W(SEQ_W), .LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .seq_idx   (seq_idx),
    .xfer_addr (xfer_addr),
    .xfer_len  (xfer_len),
    .tbl_raddr (tbl_raddr),
    .tbl_word  (tbl_word),
    .tx_empty  (tx_empty),
    .tx_byte   (tx_byte),
    .tx_pop    (tx_pop),
    .rx_full   (rx_full),
    .rx_push   (rx_push),
    .rx_byte   (rx_byte),
    .busy      (busy),
    .done      (done),
    .sck       (sck),
    .cs_n      (cs_n),
    .io_out    (io_out),
    .io_oe     (io_oe),
    .io_in     (io_in)
  );

endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       sck,
  input logic       cs_n,
  input logic [3:0] io_oe,
  input logic       rx_full,
  input logic       rx_pop
);

  // R2: a trigger seen while idle makes the engine busy
  assert_start_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3: sck only toggles inside a selected transaction
  assert_sck_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);

  // R3: sck high lasts exactly one clk cycle
  assert_sck_high_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |=> !sck);

  // R3: data lines are driven only while selected
  assert_oe_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe != 4'b0000) |-> !cs_n);

  // R8: receive FIFO stays full until popped
  assert_rx_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_pop) |=> rx_full);

  // R9: done coincides with released select
  assert_done_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);

  // R9: done lasts one cycle and busy drops right after
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

bind flash_seq_engine flash_seq_checker u_flash_seq_checker (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .sck     (sck),
  .cs_n    (cs_n),
  .io_oe   (io_oe),
  .rx_full (rx_full),
  .rx_pop  (rx_pop)
);

// File: tb/test_flash_seq_engine.sv
`timescale 1ns/1ps
module test_flash_seq_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_we;
  logic [3:0]  tbl_addr;
  logic [31:0] tbl_wdata;
  logic        start;
  logic [1:0]  seq_idx;
  logic [31:0] xfer_addr;
  logic [7:0]  xfer_len;
  logic        busy, done;
  logic        tx_push;
  logic [7:0]  tx_data;
  logic        tx_full;
  logic        rx_pop;
  logic [7:0]  rx_data;
  logic        rx_empty;
  logic        sck, cs_n;
  logic [3:0]  io_out, io_oe, io_in;

  always #5 clk = ~clk;

  flash_seq_engine i_flash_seq_engine (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .start(start), .seq_idx(seq_idx), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .busy(busy), .done(done), .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int total = 0;
  int bad   = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // flash model: io_in is a known function of falling sck edges so far
  function automatic logic [3:0] pat(int k);
    return 4'((k * 5 + 3) % 16);
  endfunction

  int nrise = 0;
  int nfall = 0;
  assign io_in = pat(nfall);

  logic [3:0] log_oe  [0:1023];
  logic [3:0] log_out [0:1023];
  always @(posedge sck) begin
    #1;
    if (nrise < 1024) begin
      log_oe[nrise]  = io_oe;
      log_out[nrise] = io_out;
    end
    nrise++;
  end
  always @(negedge sck) begin
    #1;
    nfall++;
  end

  // bench copy of the programmed table and reference streams
  logic [31:0] tbl   [0:15];
  logic [7:0]  wbytes[0:63];
  logic [3:0]  e_oe  [0:1023];
  logic [3:0]  e_out [0:1023];
  logic [7:0]  e_rx  [0:63];
  int ne, nrx;

  function automatic logic [15:0] ins(int opc, bit quad, int opnd);
    return {6'(opc), (quad ? 2'd2 : 2'd0), 8'(opnd)};
  endfunction

  task automatic emit_tx(logic [31:0] v, int nbits, bit quad);
    if (quad) begin
      for (int i = 0; i < nbits / 4; i++) begin
        e_oe[ne] = 4'b1111; e_out[ne] = v[31 - 4*i -: 4]; ne++;
      end
    end else begin
      for (int i = 0; i < nbits; i++) begin
        e_oe[ne] = 4'b0001; e_out[ne] = {3'b000, v[31 - i]}; ne++;
      end
    end
  endtask

  task automatic emit_idle(int n);
    for (int i = 0; i < n; i++) begin
      e_oe[ne] = 4'b0000; e_out[ne] = 4'b0000; ne++;
    end
  endtask

  task automatic build_exp(int idx, logic [31:0] addr, int len);
    int wi;
    logic [31:0] w;
    logic [15:0] iw;
    logic [5:0]  opc;
    bit          quad;
    int          opnd;
    logic [7:0]  b;
    ne = 0; nrx = 0; wi = 0;
    for (int ip = 0; ip < 8; ip++) begin
      w    = tbl[idx*4 + ip/2];
      iw   = (ip % 2) ? w[31:16] : w[15:0];
      opc  = iw[15:10];
      quad = (iw[9:8] == 2'd2);
      opnd = int'(iw[7:0]);
      if (opc == 6'd0 || opc > 6'd5) break;
      case (opc)
        6'd1: emit_tx({iw[7:0], 24'h0}, 8, quad);
        6'd2: emit_tx(addr << (32 - opnd), opnd, quad);
        6'd3: emit_idle(opnd);
        6'd4: for (int j = 0; j < len; j++) begin
                emit_tx({wbytes[wi], 24'h0}, 8, quad); wi++;
              end
        default: for (int j = 0; j < len; j++) begin
                if (quad) begin
                  b = {pat(ne), pat(ne + 1)};
                  emit_idle(2);
                end else begin
                  for (int k = 0; k < 8; k++) b[7 - k] = pat(ne + k)[1];
                  emit_idle(8);
                end
                e_rx[nrx] = b; nrx++;
              end
      endcase
    end
  endtask

  task automatic wr_tbl(int a, logic [31:0] d);
    @(negedge clk); tbl_we = 1'b1; tbl_addr = 4'(a); tbl_wdata = d; tbl[a] = d;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic push_tx(logic [7:0] b);
    @(negedge clk); tx_push = 1'b1; tx_data = b;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic kick(int idx, logic [31:0] addr, int len);
    build_exp(idx, addr, len);
    nrise = 0; nfall = 0;
    @(negedge clk); start = 1'b1; seq_idx = 2'(idx); xfer_addr = addr; xfer_len = 8'(len);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_run(string req);
    int t;
    int first;
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk); t++;
    end
    check(done, "R9", "done pulse seen", int'(done), 1);
    check(cs_n == 1'b1, "R9", "cs_n high with done", int'(cs_n), 1);
    @(negedge clk);
    check(!busy && !done, "R9", "idle after done", int'({busy, done}), 0);
    check(nrise == ne, req, "sck period count", nrise, ne);
    first = -1;
    for (int i = 0; i < ne && i < 1024; i++) begin
      if (first < 0 && (log_oe[i] !== e_oe[i] ||
                        (e_oe[i] != 4'b0000 && log_out[i] !== e_out[i]))) first = i;
    end
    if (first < 0) check(1'b1, req, "pin stream", 0, 0);
    else check(1'b0, req, "pin stream at edge", int'({log_oe[first], log_out[first]}),
               int'({e_oe[first], e_out[first]}));
  endtask

  task automatic drain(int from, string req);
    for (int i = from; i < nrx; i++) begin
      @(negedge clk);
      check(!rx_empty, req, "rx byte present", int'(rx_empty), 0);
      check(rx_data == e_rx[i], req, "rx byte value", int'(rx_data), int'(e_rx[i]));
      rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
    end
    @(negedge clk);
    check(rx_empty, req, "rx empty after drain", int'(rx_empty), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0; start = 1'b0;
    seq_idx = '0; xfer_addr = '0; xfer_len = '0; tx_push = 1'b0; tx_data = '0; rx_pop = 1'b0;
    for (int i = 0; i < 16; i++) tbl[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(cs_n && !sck && !busy && !done, "R1", "pins idle", int'({cs_n, sck, busy, done}), 8);
    check(io_oe == 4'b0000, "R1", "io_oe idle", int'(io_oe), 0);
    check(rx_empty && !tx_full, "R1", "fifo flags", int'({rx_empty, tx_full}), 2);

    // R13/R9: index 3 is all-zero after reset, so it ends at once
    kick(3, 32'h0, 0);
    finish_run("R9");

    // program the table (R2 layout)
    wr_tbl(0, {ins(2, 0, 24), ins(1, 0, 8'h9C)});
    wr_tbl(1, {ins(5, 1, 0), ins(3, 0, 4)});
    wr_tbl(2, 32'h0);
    wr_tbl(4, {ins(2, 1, 32), ins(1, 1, 8'hA5)});
    wr_tbl(5, {ins(0, 0, 0), ins(4, 1, 0)});
    wr_tbl(8,  {ins(1, 1, 8'h5A), ins(1, 0, 8'h3C)});
    wr_tbl(9,  {ins(2, 0, 8), ins(3, 0, 1)});
    wr_tbl(10, {ins(5, 0, 0), ins(4, 0, 0)});
    wr_tbl(11, {ins(3, 0, 2), ins(1, 1, 8'hC3)});

    // R5 R6 R8 R13: command, address, dummy, quad read over lengths and addresses
    for (int a = 0; a < 3; a++) begin
      for (int len = 0; len <= 4; len++) begin
        kick(0, 32'h00A5_3C96 ^ (a * 32'h0013_7F21), len);
        finish_run("R5");
        drain(0, "R8");
      end
    end

    // R4 R7 R13: quad command, 32-bit quad address, quad write
    for (int len = 0; len <= 4; len++) begin
      for (int i = 0; i < len; i++) wbytes[i] = 8'((len * 16 + i) * 7 + 1);
      for (int i = 0; i < len; i++) push_tx(wbytes[i]);
      kick(1, 32'hC001_D00D + len, len);
      finish_run("R4");
    end

    // R10: eight instructions with no end, one-line write and read
    for (int len = 0; len <= 3; len++) begin
      for (int i = 0; i < len; i++) wbytes[i] = 8'(8'h91 + i * 37);
      for (int i = 0; i < len; i++) push_tx(wbytes[i]);
      kick(2, 32'h0000_00E7 + len, len);
      finish_run("R10");
      drain(0, "R10");
    end

    // R7 transmit stall and R11 trigger while busy
    wbytes[0] = 8'h17; wbytes[1] = 8'hE2; wbytes[2] = 8'h6B;
    push_tx(wbytes[0]);
    kick(1, 32'h1234_5678, 3);
    repeat (60) @(negedge clk);
    check(nrise == 12, "R7", "sck periods before stall", nrise, 12);
    check(!cs_n && !sck && busy, "R7", "held while tx empty", int'({cs_n, sck, busy}), 1);
    @(negedge clk); start = 1'b1; seq_idx = 2'd3;
    @(negedge clk); start = 1'b0;
    push_tx(wbytes[1]);
    push_tx(wbytes[2]);
    finish_run("R7");
    nrise = 0;
    repeat (20) @(negedge clk);
    check(!busy && cs_n && nrise == 0, "R11", "no second transaction", nrise, 0);

    // R8 receive stall with FIFO full
    kick(0, 32'h0055_AA33, 6);
    repeat (300) @(negedge clk);
    n0 = 44;
    check(nrise == n0, "R8", "sck periods before rx stall", nrise, n0);
    check(!cs_n && busy, "R8", "held while rx full", int'({cs_n, busy}), 1);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check(rx_data == e_rx[i], "R8", "early rx byte", int'(rx_data), int'(e_rx[i]));
      rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
    end
    finish_run("R8");
    drain(2, "R8");

    // R12: push into a full transmit FIFO is dropped
    for (int i = 0; i < 4; i++) wbytes[i] = 8'(8'h20 + i * 9);
    for (int i = 0; i < 4; i++) push_tx(wbytes[i]);
    @(negedge clk);
    check(tx_full, "R12", "tx_full at 4 bytes", int'(tx_full), 1);
    push_tx(8'hEE);
    kick(1, 32'h0BAD_F00D, 4);
    finish_run("R12");
    check(!tx_full, "R12", "tx_full cleared", int'(tx_full), 0);
    wbytes[0] = 8'h42;
    push_tx(wbytes[0]);
    kick(1, 32'h0000_0001, 1);
    finish_run("R12");

    // R12: pop on empty receive FIFO changes nothing
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    check(rx_empty, "R12", "rx stays empty", int'(rx_empty), 1);
    kick(0, 32'h0076_5432, 2);
    finish_run("R12");
    drain(0, "R12");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule